// File: doc/BRIEF.md
# Two-Bit Hysteresis Branch Predictor Table

This block is a small, directly indexed table that predicts whether conditional branches are taken. Each entry holds a valid flag, an address tag for the branch that owns it, and a two-bit hysteresis state. The upper state bit is the prediction (1 = taken). The lower state bit is the outcome of the most recent resolved execution of that branch (1 = taken). A fetch stage presents a program counter on the lookup port and gets back, in the same cycle, a hit flag and a taken/not-taken prediction. When a branch resolves, the execute stage presents its address and its actual outcome on the update port. On the next rising clock edge the entry's state machine advances, or the entry is claimed for that branch if its tag does not match.

The table is indexed by the PC bits just above the instruction-alignment bits. All PC bits above the index are stored as the tag. Alignment bits take no part in either the index or the compare. The four states are named HS_NT_FIRM (00), HS_NT_WARN (01), HS_TK_WARN (10) and HS_TK_FIRM (11). A correct outcome from a warned state returns to the firm state on the same side. A second miss in a row jumps straight to the firm state on the opposite side. The prediction therefore changes only after two wrong predictions in a row.

Top module: `bp_hyst_table`

## Requirements
- R1: An active-low reset clears every valid flag, so every lookup after reset reports lk_hit = 0 until an update claims the entry.
- R2: A lookup that misses reports lk_hit = 0 and lk_taken = 0 (not taken).
- R3: The index is lk_pc[ALIGN_W+IDX_W-1:ALIGN_W] and the tag is lk_pc[PC_W-1:ALIGN_W+IDX_W]. A hit needs a valid entry with an equal tag. PC bits [ALIGN_W-1:0] are ignored.
- R4: An update whose tag misses, or that lands on an invalid entry, claims the entry. It sets the valid flag, stores the tag, and starts in HS_TK_FIRM (11) if the branch was taken or in HS_NT_FIRM (00) if it was not. A later lookup of that PC then hits and predicts the actual outcome.
- R5: From HS_NT_FIRM, a not-taken outcome stays in HS_NT_FIRM. A taken outcome moves to HS_NT_WARN, and the prediction stays not taken.
- R6: From HS_NT_WARN, a not-taken outcome returns to HS_NT_FIRM. A taken outcome moves to HS_TK_FIRM and the prediction becomes taken.
- R7: From HS_TK_FIRM, a taken outcome stays in HS_TK_FIRM. A not-taken outcome moves to HS_TK_WARN, and the prediction stays taken.
- R8: From HS_TK_WARN, a taken outcome returns to HS_TK_FIRM. A not-taken outcome moves to HS_NT_FIRM and the prediction becomes not taken.
- R9: A hit entry's prediction flips only after two consecutive mispredicted outcomes. Two updates in a row with the same outcome always leave the prediction equal to that outcome.
- R10: When a lookup and an update address the same entry in the same cycle, the lookup returns the state held before that update.
- R11: The table changes only on a cycle with upd_valid = 1, and an update alters only the entry at its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset that clears all valid flags |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_hit | output | 1 | The lookup PC owns a valid entry |
| lk_taken | output | 1 | Prediction for the lookup PC, 1 = taken, 0 on a miss |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
A behavioural reference model in the bench tracks every entry and compares both lookup outputs on every clock. Directed walks through each state drive single mispredictions, which must not flip the prediction, and double mispredictions, which must flip it; together they separate all eight transitions, including the two that are easy to swap. A second PC that shares an index but not a tag tells allocation apart from advancing the existing state. Lookups that differ only in alignment bits, or only in tag, separate the index split from the tag compare. Same-cycle lookup and update on one entry shows whether the read bypasses the write, and long random streams over a few indices and tags mix all of these with reset applied in mid-run.

// File: rtl/bp_hyst_pkg.sv
package bp_hyst_pkg;

    // Upper bit: current prediction (1 = taken).
    // Lower bit: most recent resolved outcome (1 = taken).
    typedef enum logic [1:0] {
        HS_NT_FIRM = 2'b00,
        HS_NT_WARN = 2'b01,
        HS_TK_WARN = 2'b10,
        HS_TK_FIRM = 2'b11
    } hyst_state_e;

    function automatic logic hyst_predict(hyst_state_e s);
        return s[1];
    endfunction

    function automatic hyst_state_e hyst_alloc(logic taken);
        return taken ? HS_TK_FIRM : HS_NT_FIRM;
    endfunction

endpackage

// File: rtl/bp_hyst_fsm.sv
module bp_hyst_fsm
    import bp_hyst_pkg::*;
(
    input  hyst_state_e cur_state,
    input  logic        outcome_taken,
    output hyst_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            HS_NT_FIRM: nxt_state = outcome_taken ? HS_NT_WARN : HS_NT_FIRM;
            HS_NT_WARN: nxt_state = outcome_taken ? HS_TK_FIRM : HS_NT_FIRM;
            HS_TK_WARN: nxt_state = outcome_taken ? HS_TK_FIRM : HS_NT_FIRM;
            HS_TK_FIRM: nxt_state = outcome_taken ? HS_TK_FIRM : HS_TK_WARN;
            default:    nxt_state = HS_NT_FIRM;
        endcase
    end

endmodule

// File: rtl/bp_hyst_entry.sv
module bp_hyst_entry
    import bp_hyst_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output hyst_state_e      rd_state
);

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    hyst_state_e      state_q;
    hyst_state_e      state_adv;
    logic             wr_match;

    bp_hyst_fsm u_fsm (
        .cur_state     (state_q),
        .outcome_taken (wr_taken),
        .nxt_state     (state_adv)
    );

    assign wr_match = valid_q && (tag_q == wr_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            state_q <= HS_NT_FIRM;
        end else if (wr_en) begin
            if (wr_match) begin
                state_q <= state_adv;
            end else begin
                valid_q <= 1'b1;
                tag_q   <= wr_tag;
                state_q <= hyst_alloc(wr_taken);
            end
        end
    end

    assign rd_valid = valid_q;
    assign rd_tag   = tag_q;
    assign rd_state = state_q;

endmodule

// File: rtl/bp_hyst_table.sv
module bp_hyst_table
    import bp_hyst_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int ALIGN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_LO  = ALIGN_W + IDX_W;
    localparam int TAG_W   = PC_W - TAG_LO;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] upd_idx;
    logic [TAG_W-1:0] upd_tag;

    logic             ent_valid [ENTRIES];
    logic [TAG_W-1:0] ent_tag   [ENTRIES];
    hyst_state_e      ent_state [ENTRIES];

    assign lk_idx  = lk_pc[TAG_LO-1:ALIGN_W];
    assign lk_tag  = lk_pc[PC_W-1:TAG_LO];
    assign upd_idx = upd_pc[TAG_LO-1:ALIGN_W];
    assign upd_tag = upd_pc[PC_W-1:TAG_LO];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic sel;
        assign sel = upd_valid && (upd_idx == IDX_W'(i));
        bp_hyst_entry #(.TAG_W(TAG_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel),
            .wr_tag   (upd_tag),
            .wr_taken (upd_taken),
            .rd_valid (ent_valid[i]),
            .rd_tag   (ent_tag[i]),
            .rd_state (ent_state[i])
        );
    end

    always_comb begin
        lk_hit   = ent_valid[lk_idx] && (ent_tag[lk_idx] == lk_tag);
        lk_taken = lk_hit && hyst_predict(ent_state[lk_idx]);
    end

endmodule

// File: rtl/bp_hyst_checker.sv
module bp_hyst_checker #(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic            lk_taken,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken
);

    // Empty table on the first cycle out of reset.
    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // Any update leaves its PC resident for the next lookup.
    assert_update_resident_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lk_pc[PC_W-1:ALIGN_W] != $past(upd_pc[PC_W-1:ALIGN_W])) || lk_hit);

    // Two same-outcome updates in a row pin the prediction to that outcome.
    assert_two_same_outcomes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && (upd_pc == $past(upd_pc)) &&
         (upd_taken == $past(upd_taken)))
        |=> (lk_pc[PC_W-1:ALIGN_W] != $past(upd_pc[PC_W-1:ALIGN_W])) ||
            (lk_hit && (lk_taken == $past(upd_taken))));

    // Without an update the answer for a repeated lookup does not move.
    assert_hold_without_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (lk_pc != $past(lk_pc)) ||
                       ((lk_hit == $past(lk_hit)) && (lk_taken == $past(lk_taken))));

endmodule

bind bp_hyst_table bp_hyst_checker #(.PC_W(PC_W), .ALIGN_W(ALIGN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_hit    (lk_hit),
    .lk_taken  (lk_taken),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken)
);

// File: tb/tb_bp_hyst_table.sv
`timescale 1ns/1ps
module tb_bp_hyst_table;

    localparam int PC_W    = 32;
    localparam int IDX_W   = 4;
    localparam int ALIGN_W = 2;
    localparam int NENT    = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_hit;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model: per index a valid flag, a tag, a prediction and a last outcome.
    bit          m_valid [NENT];
    longint      m_tag   [NENT];
    bit          m_pred  [NENT];
    bit          m_last  [NENT];

    always #2 clk = ~clk;

    bp_hyst_table #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'((pc >> ALIGN_W) % NENT);
    endfunction

    function automatic longint tag_of(logic [PC_W-1:0] pc);
        return longint'(pc >> (ALIGN_W + IDX_W));
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NENT; i++) m_valid[i] = 0;
    endtask

    task automatic model_update(logic [PC_W-1:0] pc, bit t);
        int i = idx_of(pc);
        if (!(m_valid[i] && m_tag[i] == tag_of(pc))) begin
            m_valid[i] = 1; m_tag[i] = tag_of(pc); m_pred[i] = t; m_last[i] = t;
        end else if (m_pred[i] == t) begin
            m_last[i] = t;
        end else if (m_last[i] == m_pred[i]) begin
            m_last[i] = t;              // first miss: keep the prediction
        end else begin
            m_pred[i] = t; m_last[i] = t; // second miss in a row: flip
        end
    endtask

    task automatic check(string req, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s pc=%h actual=%0b expected=%0b", req, what, lk_pc, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare against the pre-update model, then advance it.
    task automatic step(string req, logic [PC_W-1:0] lpc, bit uv, logic [PC_W-1:0] upc, bit ut);
        bit eh, et;
        int li;
        @(negedge clk);
        lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        li = idx_of(lpc);
        eh = m_valid[li] && (m_tag[li] == tag_of(lpc));
        et = eh && m_pred[li];
        check(req, "hit", lk_hit, eh);
        check(req, "taken", lk_taken, et);
        if (uv) model_update(upc, ut);
    endtask

    task automatic look(string req, logic [PC_W-1:0] lpc);
        step(req, lpc, 0, '0, 0);
    endtask

    task automatic upd(string req, logic [PC_W-1:0] pc, bit t);
        step(req, pc, 1, pc, t);
        look(req, pc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; upd_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    // Explicit expected-value check on top of the model comparison.
    task automatic expect_pred(string req, logic [PC_W-1:0] pc, bit eh, bit et);
        @(negedge clk);
        lk_pc = pc; upd_valid = 0;
        #1;
        check(req, "directed hit", lk_hit, eh);
        check(req, "directed taken", lk_taken, et);
    endtask

    localparam logic [PC_W-1:0] PC_A  = 32'h0000_1234;
    localparam logic [PC_W-1:0] PC_B  = 32'h0000_5234; // same index as PC_A, other tag
    localparam logic [PC_W-1:0] PC_C  = 32'h0000_1240; // different index

    initial begin
        model_clear();
        do_reset();
        // R1, R2: empty table after reset
        look("R1", PC_A); look("R1", PC_B); look("R2", PC_C);
        expect_pred("R1", PC_A, 0, 0);

        // R4: allocate taken -> firm taken; R3: alignment bits ignored, other tag misses
        upd("R4", PC_A, 1);
        expect_pred("R4", PC_A, 1, 1);
        expect_pred("R3", PC_A | 32'h3, 1, 1);
        expect_pred("R3", PC_B, 0, 0);

        // R7: 11 -NT-> 10 keeps taken; R8: 10 -T-> 11
        upd("R7", PC_A, 0); expect_pred("R7", PC_A, 1, 1);
        upd("R8", PC_A, 1); expect_pred("R8", PC_A, 1, 1);
        // R9, R8: two misses flip 11 -> 10 -> 00
        upd("R7", PC_A, 0); upd("R8", PC_A, 0); expect_pred("R9", PC_A, 1, 0);
        // R5: 00 -NT-> 00, 00 -T-> 01 still not taken
        upd("R5", PC_A, 0); expect_pred("R5", PC_A, 1, 0);
        upd("R5", PC_A, 1); expect_pred("R5", PC_A, 1, 0);
        // R6: 01 -NT-> 00, then 00 -T-> 01 -T-> 11
        upd("R6", PC_A, 0); expect_pred("R6", PC_A, 1, 0);
        upd("R5", PC_A, 1); upd("R6", PC_A, 1); expect_pred("R6", PC_A, 1, 1);

        // R10: same-cycle lookup returns pre-update prediction
        upd("R7", PC_A, 0);                         // now 10, predicting taken
        @(negedge clk);
        lk_pc = PC_A; upd_valid = 1; upd_pc = PC_A; upd_taken = 0;
        #1;
        check("R10", "same-cycle taken", lk_taken, 1'b1);
        model_update(PC_A, 0);
        expect_pred("R10", PC_A, 1, 0);

        // R11: other entry untouched by updates at PC_A's index
        upd("R4", PC_C, 1);
        for (int k = 0; k < 4; k++) upd("R11", PC_A, k[0]);
        expect_pred("R11", PC_C, 1, 1);

        // R4: alias at the same index replaces the owner
        upd("R4", PC_B, 0);
        expect_pred("R4", PC_B, 1, 0);
        expect_pred("R3", PC_A, 0, 0);

        // R1: reset in mid-run
        do_reset();
        expect_pred("R1", PC_C, 0, 0);
        look("R1", PC_B);

        // R9: random mix over a few indices and tags, model compared every cycle
        for (int n = 0; n < 6000; n++) begin
            logic [PC_W-1:0] lp, up;
            lp = {24'($urandom_range(0, 2)), 4'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'b00};
            lp = lp | PC_W'($urandom_range(0, 3));
            up = {24'($urandom_range(0, 2)), 4'($urandom_range(0, 3)), 4'h0};
            if ($urandom_range(0, 3) == 0) up = lp;
            step("R9", lp, $urandom_range(0, 2) != 0, up, $urandom_range(0, 1) == 1);
            if (n == 3000) do_reset();
        end

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #400000;
                errors++;
                checks++;
                $display("FAIL watchdog expired before the sequence ended");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule